// File: doc/BRIEF.md
# Return-Address Stack with Fault Interrupt Request

This block is a small last-in, first-out store kept inside the processor for return addresses and saved data. It holds ten 16-bit words. The processor can push a word, pull a word, or do both in one cycle. The interrupt-response sequence has its own push port for the program counter. The current top word always appears on the read port, so a pull presents the word it removes in the same cycle. The fill level appears on a port, and the top entry sits at index `level - 1`.

When stack interrupts are enabled, the block sends a one-cycle request to the interrupt controller in two cases: a pull on an empty stack, and a push that fills the ninth word. The ninth word is filled when eight entries are present, so the top index is 7. The request fires one word early on purpose. The tenth word then stays free for the program counter that the fault's own interrupt response pushes. When stack interrupts are disabled, no request is ever raised and all ten words can be used. A push into a full stack and a pull from an empty stack leave the level unchanged; they never wrap.

Top module: `return_stack`

## Requirements
- R1: After a synchronous active-low reset, `level_o` is 0, `fault_req_o` is 0 and `rd_data_o` is 0.
- R2: A push (`push_i` high) below level 10 stores `wr_data_i` at index `level_o`, and `level_o` rises by one at the clock edge; `rd_data_o` then shows that word.
- R3: While `pull_i` is high and the level is above 0, `rd_data_o` shows the top word (index `level_o - 1`) in that same cycle, and `level_o` falls by one at the clock edge.
- R4: With `stk_irq_en_i` high, any push taken at level 8 stores the ninth word, and `fault_req_o` is high in the following cycle.
- R5: After a full fault, a push at level 9 stores the tenth word without raising `fault_req_o`.
- R6: With `stk_irq_en_i` high, a pull at level 0 leaves the level at 0 and drives `fault_req_o` high in the following cycle.
- R7: With `stk_irq_en_i` low, `fault_req_o` stays 0 for every command, and all ten words can be filled and read back in LIFO order.
- R8: A push at level 10 leaves the level and the stored words unchanged and raises no request, whatever the enable.
- R9: When `irq_push_i` is high, the block pushes `irq_pc_i`, and `push_i` and `pull_i` in the same cycle are ignored.
- R10: When `push_i` and `pull_i` are high together and the level is above 0, `rd_data_o` shows the old top word in that cycle, the top word is replaced by `wr_data_i`, and the level is unchanged. At level 0 this pair acts as a plain push and raises no request.
- R11: `fault_req_o` is high only in the cycle right after an offending command, and for one cycle per offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Ordinary push strobe |
| pull_i | input | 1 | Pull strobe |
| wr_data_i | input | 16 | Word for an ordinary push |
| irq_push_i | input | 1 | Push strobe from the interrupt-response sequence |
| irq_pc_i | input | 16 | Program counter saved by the interrupt response |
| stk_irq_en_i | input | 1 | Stack interrupt enable |
| rd_data_o | output | 16 | Current top word, 0 when empty |
| level_o | output | 4 | Number of stored words, 0 to 10 |
| fault_req_o | output | 1 | One-cycle stack fault request to the interrupt controller |

## Verification
Two functions can fall in the same cycle. A push can meet a pull, which becomes an in-place exchange. An interrupt-response push can meet an ordinary push and pull, and in that case only the interrupt push counts. The bench drives these overlapping strobes on purpose, including the exchange at level 0 and the interrupt push right after a full fault. A behavioural queue model decides which command took effect. The read port is compared before each edge, and the level and the fault request after it.

// File: rtl/rstk_pkg.sv
// Package: shared command encoding for the return stack.
// Assumes: imported by every module of the block.
package rstk_pkg;
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_PULL = 3'd2,
        OP_SWAP = 3'd3,
        OP_IRQ  = 3'd4
    } rstk_op_e;
endpackage

// File: rtl/rstk_cmd_decode.sv
// Module: rstk_cmd_decode
// Turns the raw strobes into one command per cycle and selects the write word.
// The interrupt push overrides the others. A push together with a pull becomes
// an exchange, or a plain push when the stack is empty.
// Assumes: strobes are synchronous to clk.
module rstk_cmd_decode
    import rstk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LVL_W = 4
) (
    input  logic             push_i,
    input  logic             pull_i,
    input  logic             irq_push_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] irq_pc_i,
    input  logic [LVL_W-1:0] level_i,
    output rstk_op_e         op_o,
    output logic [WIDTH-1:0] wdata_o
);
    // Command priority: interrupt push first, then exchange, then single strobes.
    always_comb begin
        if (irq_push_i)                  op_o = OP_IRQ;
        else if (push_i && pull_i)       op_o = (level_i == '0) ? OP_PUSH : OP_SWAP;
        else if (push_i)                 op_o = OP_PUSH;
        else if (pull_i)                 op_o = OP_PULL;
        else                             op_o = OP_IDLE;
    end

    // Write word source: the saved program counter for interrupt pushes.
    always_comb begin
        wdata_o = irq_push_i ? irq_pc_i : wr_data_i;
    end
endmodule

// File: rtl/rstk_ptr_ctrl.sv
// Module: rstk_ptr_ctrl
// Keeps the fill level, computes the write index and raises the fault pulse.
// Full fault: any push taken at FULL_LEVEL. Empty fault: a pull at level 0.
// Faults are only raised while the enable is high. The level saturates.
// Assumes: op_i comes from rstk_cmd_decode, so OP_SWAP implies level > 0.
module rstk_ptr_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH      = 10,
    parameter int FULL_LEVEL = 8,
    parameter int LVL_W      = 4,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rstk_op_e         op_i,
    input  logic             irq_en_i,
    output logic [LVL_W-1:0] level_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             fault_req_o
);
    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_WARN = LVL_W'(FULL_LEVEL);

    logic [LVL_W-1:0] level_q;
    logic             push_like;
    logic             take_push;
    logic             take_pull;
    logic             fault_d;

    // Classify the command against the current level.
    always_comb begin
        push_like = (op_i == OP_PUSH) || (op_i == OP_IRQ);
        take_push = push_like && (level_q != LVL_TOP);
        take_pull = (op_i == OP_PULL) && (level_q != '0);
    end

    // Write port control: a new slot for a push, the top slot for an exchange.
    always_comb begin
        wr_en_o  = take_push || (op_i == OP_SWAP);
        wr_idx_o = take_push ? IDX_W'(level_q) : IDX_W'(level_q - 1'b1);
    end

    // Fault decision for this cycle's command.
    always_comb begin
        fault_d = irq_en_i &&
                  ((push_like && (level_q == LVL_WARN)) ||
                   ((op_i == OP_PULL) && (level_q == '0)));
    end

    // Level register, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)          level_q <= '0;
        else if (take_push)  level_q <= level_q + 1'b1;
        else if (take_pull)  level_q <= level_q - 1'b1;
    end

    // Fault request register: one cycle per offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_req_o <= 1'b0;
        else        fault_req_o <= fault_d;
    end

    assign level_o = level_q;

    // R4: a push at the warning level while enabled yields a request.
    p_full_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_like && irq_en_i && level_q == LVL_WARN) |=> fault_req_o);

    // R6: a pull on an empty stack keeps the level at zero.
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_PULL) && level_q == '0) |=> (level_q == '0));

    // R8: a push into a full stack does not move the level.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_like && level_q == LVL_TOP) |=> $stable(level_q));

    // R2: the level never exceeds the capacity.
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_TOP);
endmodule

// File: rtl/rstk_store.sv
// Module: rstk_store
// The word array with one write port and a read port for the top entry.
// Assumes: wr_idx_i < DEPTH whenever wr_en_i is high.
module rstk_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_valid_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // One storage word, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     word_q[g] <= '0;
            else if (wr_en_i && wr_idx_i == IDX_W'(g))      word_q[g] <= wr_data_i;
        end
    end

    // Top-word read mux; zero when the stack is empty.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_valid_i && rd_idx_i == IDX_W'(i)) rd_data_o = word_q[i];
        end
    end

    // R2: writes stay inside the array.
    p_wr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_idx_i < IDX_W'(DEPTH)));
endmodule

// File: rtl/return_stack.sv
// Module: return_stack (top)
// A ten-word LIFO for return addresses, with the stack fault interrupt request.
// Assumes: a synchronous active-low reset and single-clock use.
module return_stack
    import rstk_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int DEPTH      = 10,
    parameter int FULL_LEVEL = 8,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pull_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             irq_push_i,
    input  logic [WIDTH-1:0] irq_pc_i,
    input  logic             stk_irq_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic [LVL_W-1:0] level_o,
    output logic             fault_req_o
);
    localparam int IDX_W = $clog2(DEPTH) < 1 ? 1 : $clog2(DEPTH);

    rstk_op_e         op;
    logic [WIDTH-1:0] wdata;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             rd_valid;
    logic [IDX_W-1:0] rd_idx;

    rstk_cmd_decode #(.WIDTH(WIDTH), .LVL_W(LVL_W)) u_dec (
        .push_i     (push_i),
        .pull_i     (pull_i),
        .irq_push_i (irq_push_i),
        .wr_data_i  (wr_data_i),
        .irq_pc_i   (irq_pc_i),
        .level_i    (level_o),
        .op_o       (op),
        .wdata_o    (wdata)
    );

    rstk_ptr_ctrl #(.DEPTH(DEPTH), .FULL_LEVEL(FULL_LEVEL), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .irq_en_i    (stk_irq_en_i),
        .level_o     (level_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .fault_req_o (fault_req_o)
    );

    // Top entry address for the read port.
    always_comb begin
        rd_valid = (level_o != '0);
        rd_idx   = IDX_W'(level_o - 1'b1);
    end

    rstk_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wdata),
        .rd_valid_i (rd_valid),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data_o)
    );

    // R7: a request is only raised while stack interrupts were enabled.
    p_fault_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req_o |-> $past(stk_irq_en_i));

    // R10: an exchange leaves the level where it was.
    p_swap_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pull_i && !irq_push_i && level_o != '0) |=> $stable(level_o));
endmodule

// File: tb/tb_return_stack.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared against the block on every clock.
module tb_return_stack;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_i, pull_i, irq_push_i, stk_irq_en_i;
    logic [15:0] wr_data_i, irq_pc_i;
    logic [15:0] rd_data_o;
    logic [3:0]  level_o;
    logic        fault_req_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] q[$];
    bit          exp_fault;

    always #2.5 clk = ~clk;

    return_stack dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pull_i(pull_i),
        .wr_data_i(wr_data_i), .irq_push_i(irq_push_i), .irq_pc_i(irq_pc_i),
        .stk_irq_en_i(stk_irq_en_i), .rd_data_o(rd_data_o),
        .level_o(level_o), .fault_req_o(fault_req_o)
    );

    function automatic logic [15:0] top();
        return (q.size() == 0) ? 16'h0 : q[q.size()-1];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One command: drive at the falling edge, check the read port, then the result.
    task automatic step(string req, bit p, bit l, bit irq, logic [15:0] d, logic [15:0] pc);
        push_i = p; pull_i = l; irq_push_i = irq; wr_data_i = d; irq_pc_i = pc;
        #1;
        check(req, "rd_data before edge", rd_data_o, top());
        exp_fault = 1'b0;
        if (irq || (p && !l) || (p && l && q.size() == 0)) begin
            logic [15:0] w;
            w = irq ? pc : d;
            if (stk_irq_en_i && q.size() == 8) exp_fault = 1'b1;
            if (q.size() < 10) q.push_back(w);
        end else if (p && l) begin
            q[q.size()-1] = d;
        end else if (l) begin
            if (q.size() == 0) exp_fault = stk_irq_en_i;
            else void'(q.pop_back());
        end
        @(negedge clk);
        check(req, "level", level_o, q.size());
        check(req, "fault_req", fault_req_o, exp_fault);
        check(req, "rd_data after edge", rd_data_o, top());
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; push_i = 0; pull_i = 0; irq_push_i = 0;
        wr_data_i = 0; irq_pc_i = 0; stk_irq_en_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "level after reset", level_o, 0);
        check("R1", "fault after reset", fault_req_o, 0);
        check("R1", "rd_data after reset", rd_data_o, 0);

        // Fill to eight with enable high.
        for (int k = 0; k < 8; k++) step("R2", 1, 0, 0, 16'h1000 + 16'(k), 16'h0);
        step("R3", 0, 1, 0, 16'h0, 16'h0);
        step("R2", 1, 0, 0, 16'h1107, 16'h0);
        step("R4", 1, 0, 0, 16'h1808, 16'h0);          // ninth word -> fault
        step("R5", 0, 0, 1, 16'h0, 16'hBEEF);          // tenth word from interrupt
        step("R8", 1, 0, 0, 16'hDEAD, 16'h0);          // full: ignored
        step("R9", 1, 1, 1, 16'h5555, 16'hAAAA);       // irq push at full: all ignored
        for (int k = 0; k < 10; k++) step("R3", 0, 1, 0, 16'h0, 16'h0);
        step("R6", 0, 1, 0, 16'h0, 16'h0);
        step("R11", 0, 1, 0, 16'h0, 16'h0);            // second offending pull
        step("R11", 0, 0, 0, 16'h0, 16'h0);            // no request without cause
        step("R10", 1, 1, 0, 16'h2222, 16'h0);         // exchange at empty: push
        step("R2", 1, 0, 0, 16'h3333, 16'h0);
        step("R10", 1, 1, 0, 16'h4444, 16'h0);         // exchange
        step("R9", 1, 1, 1, 16'h6666, 16'h7777);       // irq wins over push/pull
        step("R3", 0, 1, 0, 16'h0, 16'h0);
        step("R3", 0, 1, 0, 16'h0, 16'h0);
        step("R3", 0, 1, 0, 16'h0, 16'h0);

        // Enable low: ten words, no requests.
        stk_irq_en_i = 1'b0;
        step("R7", 0, 1, 0, 16'h0, 16'h0);
        for (int k = 0; k < 10; k++) step("R7", 1, 0, 0, 16'h9000 + 16'(k), 16'h0);
        step("R8", 1, 0, 0, 16'hEEEE, 16'h0);
        step("R8", 0, 0, 1, 16'h0, 16'hCCCC);
        for (int k = 0; k < 10; k++) step("R7", 0, 1, 0, 16'h0, 16'h0);
        step("R7", 0, 1, 0, 16'h0, 16'h0);

        // Reset mid-use.
        stk_irq_en_i = 1'b1;
        step("R2", 1, 0, 0, 16'h0ABC, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        q.delete();
        check("R1", "level after second reset", level_o, 0);
        check("R1", "rd_data after second reset", rd_data_o, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule